// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Engine

This block encrypts one 128-bit block under a 128-bit key with the standard ten-round AES-128 cipher. It is sized for area. The data path holds a single 8-bit substitution unit that is fed one state byte per clock. Column mixing and round-key addition work on one 32-bit column at a time. Byte 0 of every 128-bit bus is bits 127:120 and byte 15 is bits 7:0. Column c is bytes 4c to 4c+3.

A one-cycle `start` pulse seen while the engine is idle captures `key` and `plaintext` and raises `busy`. The engine first expands all eleven round keys into internal storage. It then loads the plaintext and adds round key 0. After that it runs the byte-serial rounds. The row rotation is folded into the read addressing, so it costs no cycles. The last round skips column mixing.

The parameter `OVERLAP` selects the column schedule. With `OVERLAP`=1, each column is mixed in the same cycle its fourth byte is substituted, so the rounds run back to back. With `OVERLAP`=0, a five-cycle column phase follows the sixteen substitutions of every round. When the result is ready, `ciphertext` updates, `done` pulses for one cycle and `busy` drops.

Top module: `aes_byte_serial`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a in both schedule modes.
- R2: With OVERLAP=1, `done` is high in the cycle that follows the 172nd rising edge after the edge that accepts `start`. This count is 12 cycles of key expansion and load plus 160 substitution cycles, with no idle cycle between rounds.
- R3: With OVERLAP=0, the same latency is 222 cycles: each of the ten rounds adds a 5-cycle column phase after its 16 substitutions.
- R4: A `start` pulse while `busy` is high is ignored. The running operation, its result and its timing are unchanged.
- R5: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after the accepting edge and falls in the cycle where `done` is high.
- R6: `ciphertext` changes only in a cycle where `done` is high, and otherwise holds its value.
- R7: After a synchronous reset, `busy`, `done` and `ciphertext` are all zero.
- R8: `key` and `plaintext` are captured at the accepting edge. Round-key expansion completes before the plaintext enters the state. Changes to either input after that edge do not affect the result.
- R9: For arbitrary key and plaintext values, the ciphertext equals the AES-128 encryption of the captured plaintext under the captured key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an encryption; ignored while busy |
| key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| plaintext | input | 128 | Input block, byte 0 in bits 127:120 |
| ciphertext | output | 128 | Result block, held until the next completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when ciphertext is updated |

## Verification
The condition hardest to reach from the ports is the engine being mid-operation while new requests and new data arrive. This covers a second `start` during the substitution rounds, and key and plaintext changing right after the accepting edge. These are the only ways to show that the captured values and the timing are immune to the inputs. The stimulus drives both schedule variants with one shared input stream. It changes the key and plaintext one cycle after acceptance, and it pulses `start` again forty cycles into a run. A cycle-accurate behavioural model predicts `busy`, `done` and `ciphertext` every clock for each variant.

// File: rtl/aes_ser_pkg.sv
package aes_ser_pkg;
    localparam int NB_BYTES   = 16;
    localparam int NB_COLS    = 4;
    localparam int NUM_ROUNDS = 10;
    localparam int RIDX_W     = $clog2(NUM_ROUNDS + 1);
    localparam int BIDX_W     = $clog2(NB_BYTES);

    typedef logic [7:0]   byte_t;
    typedef logic [31:0]  word_t;
    typedef logic [127:0] block_t;

    typedef enum logic [2:0] {ST_IDLE, ST_KEY, ST_LOAD, ST_SUB, ST_GAP} phase_e;

    function automatic byte_t gf_xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = gf_xtime(aa);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (zero maps to zero)
    function automatic byte_t gf_inv(byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t sbox_fn(byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    function automatic byte_t rcon_fn(int r);
        byte_t c;
        c = 8'h01;
        for (int i = 1; i < NUM_ROUNDS; i++) begin
            if (i < r) c = gf_xtime(c);
        end
        return c;
    endfunction

    function automatic byte_t blk_byte(block_t v, int i);
        return v[127-8*i -: 8];
    endfunction

    // source position of output byte i after the row rotation
    function automatic int sr_src(int i);
        return (i % 4) + 4 * (((i / 4) + (i % 4)) % 4);
    endfunction

    function automatic word_t mix_col(word_t w);
        byte_t a0, a1, a2, a3;
        a0 = w[31:24];
        a1 = w[23:16];
        a2 = w[15:8];
        a3 = w[7:0];
        return {gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3,
                gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3)};
    endfunction
endpackage

// File: rtl/aes_ser_sbox.sv
module aes_ser_sbox
    import aes_ser_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);
    assign dout = sbox_fn(din);
endmodule

// File: rtl/aes_ser_col.sv
module aes_ser_col
    import aes_ser_pkg::*;
(
    input  word_t col,
    input  word_t rkey,
    input  logic  final_rnd,
    output word_t res
);
    assign res = (final_rnd ? col : mix_col(col)) ^ rkey;
endmodule

// File: rtl/aes_ser_key.sv
module aes_ser_key
    import aes_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  block_t            key_in,
    input  logic [RIDX_W-1:0] rd_idx,
    output block_t            rd_key,
    output logic              ready
);
    block_t            mem [NUM_ROUNDS+1];
    block_t            last;
    block_t            nxt_key;
    logic [RIDX_W-1:0] kidx;
    logic              running;
    word_t             rot, sub;
    word_t             w0, w1, w2, w3;

    assign rot = {last[23:0], last[31:24]};

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_subword
            aes_ser_sbox u_sb (.din(rot[31-8*g -: 8]), .dout(sub[31-8*g -: 8]));
        end
    endgenerate

    always_comb begin
        w0 = last[127:96] ^ sub ^ {rcon_fn(int'(kidx)), 24'h0};
        w1 = last[95:64] ^ w0;
        w2 = last[63:32] ^ w1;
        w3 = last[31:0]  ^ w2;
        nxt_key = {w0, w1, w2, w3};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            ready   <= 1'b0;
            kidx    <= '0;
            last    <= '0;
        end else begin
            ready <= 1'b0;
            if (kick) begin
                last    <= key_in;
                kidx    <= RIDX_W'(1);
                running <= 1'b1;
            end else if (running) begin
                last <= nxt_key;
                kidx <= kidx + RIDX_W'(1);
                if (kidx == RIDX_W'(NUM_ROUNDS)) begin
                    running <= 1'b0;
                    ready   <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (kick)         mem[0]    <= key_in;
        else if (running) mem[kidx] <= nxt_key;
    end

    assign rd_key = mem[rd_idx];

    // R8: expansion index stays within the eleven stored keys
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst)
        running |-> (kidx >= RIDX_W'(1) && kidx <= RIDX_W'(NUM_ROUNDS)));
    // R8: completion is signalled only once the expansion has run
    p_ready_after_run_r8: assert property (@(posedge clk) disable iff (rst)
        ready |-> !running && $past(running));
endmodule

// File: rtl/aes_byte_serial.sv
module aes_byte_serial
    import aes_ser_pkg::*;
#(
    parameter bit OVERLAP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [127:0] key,
    input  logic [127:0] plaintext,
    output logic [127:0] ciphertext,
    output logic         busy,
    output logic         done
);
    localparam int GAP_LEN = NB_COLS + 1;
    localparam int GCNT_W  = $clog2(GAP_LEN);

    phase_e            st;
    logic [RIDX_W-1:0] rnd;
    logic [BIDX_W-1:0] bidx;
    logic [GCNT_W-1:0] gcnt;
    block_t            cur, nxt, pt_q;
    block_t            rkey;
    logic              ks_ready;
    logic              kick;
    byte_t             s_in, s_out;
    block_t            nxt_b, wsrc, nxt_w;
    logic [1:0]        col_sel;
    logic              col_en;
    logic              last_rnd;
    logic              last_byte;
    word_t             col_res;

    assign kick      = (st == ST_IDLE) && start;
    assign last_rnd  = (rnd == RIDX_W'(NUM_ROUNDS));
    assign last_byte = (bidx == BIDX_W'(NB_BYTES - 1));

    aes_ser_key u_key (
        .clk(clk), .rst(rst), .kick(kick), .key_in(key),
        .rd_idx(rnd), .rd_key(rkey), .ready(ks_ready)
    );

    assign s_in = blk_byte(cur, sr_src(int'(bidx)));

    aes_ser_sbox u_sbox (.din(s_in), .dout(s_out));

    always_comb begin
        nxt_b = nxt;
        nxt_b[127-8*int'(bidx) -: 8] = s_out;
        wsrc    = (st == ST_SUB) ? nxt_b : nxt;
        col_sel = (st == ST_SUB) ? bidx[3:2] : gcnt[1:0];
        col_en  = (st == ST_SUB && OVERLAP && bidx[1:0] == 2'd3) ||
                  (st == ST_GAP && gcnt < GCNT_W'(NB_COLS));
    end

    aes_ser_col u_col (
        .col(wsrc[127-32*int'(col_sel) -: 32]),
        .rkey(rkey[127-32*int'(col_sel) -: 32]),
        .final_rnd(last_rnd),
        .res(col_res)
    );

    always_comb begin
        nxt_w = wsrc;
        if (col_en) nxt_w[127-32*int'(col_sel) -: 32] = col_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            busy       <= 1'b0;
            done       <= 1'b0;
            ciphertext <= '0;
            rnd        <= '0;
            bidx       <= '0;
            gcnt       <= '0;
            cur        <= '0;
            nxt        <= '0;
            pt_q       <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st   <= ST_KEY;
                    busy <= 1'b1;
                    pt_q <= plaintext;
                    rnd  <= '0;
                end
                ST_KEY: if (ks_ready) st <= ST_LOAD;
                ST_LOAD: begin
                    cur  <= pt_q ^ rkey;
                    rnd  <= RIDX_W'(1);
                    bidx <= '0;
                    st   <= ST_SUB;
                end
                ST_SUB: begin
                    nxt  <= nxt_w;
                    bidx <= bidx + BIDX_W'(1);
                    if (last_byte) begin
                        if (OVERLAP) begin
                            cur <= nxt_w;
                            if (last_rnd) begin
                                ciphertext <= nxt_w;
                                done       <= 1'b1;
                                busy       <= 1'b0;
                                st         <= ST_IDLE;
                            end else begin
                                rnd <= rnd + RIDX_W'(1);
                            end
                        end else begin
                            st   <= ST_GAP;
                            gcnt <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    nxt  <= nxt_w;
                    gcnt <= gcnt + GCNT_W'(1);
                    if (gcnt == GCNT_W'(GAP_LEN - 1)) begin
                        cur  <= nxt;
                        bidx <= '0;
                        if (last_rnd) begin
                            ciphertext <= nxt;
                            done       <= 1'b1;
                            busy       <= 1'b0;
                            st         <= ST_IDLE;
                        end else begin
                            rnd <= rnd + RIDX_W'(1);
                            st  <= ST_SUB;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: completion strobe lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5: busy only falls together with the completion strobe
    p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R6: result register moves only on completion
    p_ct_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ciphertext) |-> done);
    // R8: plaintext enters the state only after key expansion reported ready
    p_key_first_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD) |-> $past(ks_ready));
    // R2: overlapped schedule starts the next round right away
    p_no_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (OVERLAP && st == ST_SUB && last_byte && !last_rnd) |=> (st == ST_SUB && bidx == '0));
    // R3: gap schedule enters the column phase after the 16th byte
    p_gap_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (!OVERLAP && st == ST_SUB && last_byte) |=> (st == ST_GAP && gcnt == '0));
endmodule

// File: tb/aes_byte_serial_test.sv
`timescale 1ns/1ps
module aes_byte_serial_test;
    typedef logic [7:0] bt_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] plaintext = '0;
    logic [127:0] ct_o [2];
    logic         busy_o [2];
    logic         done_o [2];

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    bt_t sbt [256];

    logic [127:0] mct [2];
    logic [127:0] mexp [2];
    logic         mbusy [2];
    logic         mdone [2];
    int           mcnt [2];
    int           st_cyc [2];
    int           lat_meas [2];
    int           lat_exp [2];

    always #2.5 clk = ~clk;

    aes_byte_serial #(.OVERLAP(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start), .key(key), .plaintext(plaintext),
        .ciphertext(ct_o[0]), .busy(busy_o[0]), .done(done_o[0]));

    aes_byte_serial #(.OVERLAP(1'b0)) uut_gap (
        .clk(clk), .rst(rst), .start(start), .key(key), .plaintext(plaintext),
        .ciphertext(ct_o[1]), .busy(busy_o[1]), .done(done_o[1]));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bt_t xt(bt_t a);
        return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic bt_t rl(bt_t v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [127:0] aes_ref(logic [127:0] k, logic [127:0] p);
        bt_t s [16];
        bt_t t [16];
        bt_t w [176];
        bt_t tmp [4];
        bt_t rc;
        bt_t sv;
        logic [127:0] r;
        for (int i = 0; i < 16; i++) begin
            w[i] = k[127-8*i -: 8];
            s[i] = p[127-8*i -: 8] ^ w[i];
        end
        rc = 8'h01;
        for (int i = 16; i < 176; i += 4) begin
            for (int j = 0; j < 4; j++) tmp[j] = w[i-4+j];
            if (i % 16 == 0) begin
                sv = tmp[0];
                tmp[0] = sbt[tmp[1]] ^ rc;
                tmp[1] = sbt[tmp[2]];
                tmp[2] = sbt[tmp[3]];
                tmp[3] = sbt[sv];
                rc = xt(rc);
            end
            for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ tmp[j];
        end
        for (int rd = 1; rd <= 10; rd++) begin
            for (int row = 0; row < 4; row++)
                for (int col = 0; col < 4; col++)
                    t[row + 4*col] = sbt[s[row + 4*((col + row) % 4)]];
            for (int col = 0; col < 4; col++) begin
                if (rd < 10) begin
                    for (int row = 0; row < 4; row++)
                        s[4*col+row] = xt(t[4*col+row]) ^ xt(t[4*col+(row+1)%4]) ^ t[4*col+(row+1)%4]
                                     ^ t[4*col+(row+2)%4] ^ t[4*col+(row+3)%4];
                end else begin
                    for (int row = 0; row < 4; row++) s[4*col+row] = t[4*col+row];
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*rd + i];
        end
        for (int i = 0; i < 16; i++) r[127-8*i -: 8] = s[i];
        return r;
    endfunction

    initial begin
        bt_t p, q, x;
        p = 8'h01;
        q = 8'h01;
        do begin
            p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sbt[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sbt[0] = 8'h63;
    end

    initial begin
        lat_exp[0] = 172;
        lat_exp[1] = 222;
    end

    // cycle-accurate reference model of both variants
    always @(posedge clk) begin
        cyc++;
        for (int m = 0; m < 2; m++) begin
            if (rst) begin
                mbusy[m] = 1'b0;
                mdone[m] = 1'b0;
                mct[m]   = '0;
                mcnt[m]  = 0;
            end else begin
                mdone[m] = 1'b0;
                if (mbusy[m]) begin
                    mcnt[m]++;
                    if (mcnt[m] == lat_exp[m]) begin
                        mbusy[m] = 1'b0;
                        mdone[m] = 1'b1;
                        mct[m]   = mexp[m];
                    end
                end else if (start) begin
                    mbusy[m]  = 1'b1;
                    mcnt[m]   = 0;
                    st_cyc[m] = cyc;
                    mexp[m]   = aes_ref(key, plaintext);
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            for (int m = 0; m < 2; m++) begin
                chk(m == 0 ? "R2 busy" : "R3 busy", 128'(busy_o[m]), 128'(mbusy[m]));
                chk("R5 done", 128'(done_o[m]), 128'(mdone[m]));
                chk("R6 ciphertext hold", ct_o[m], mct[m]);
                if (done_o[m]) lat_meas[m] = cyc - st_cyc[m];
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=60000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy_o[0] || busy_o[1]);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_op(input logic [127:0] k, input logic [127:0] p,
                          input bit change_after, input bit poke_start);
        @(negedge clk);
        key = k;
        plaintext = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (change_after) begin
            key = ~k;
            plaintext = p ^ 128'hdead_beef;
        end
        if (poke_start) begin
            repeat (40) @(negedge clk);
            key = k ^ 128'h1;
            plaintext = ~p;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        logic [127:0] kk, pp;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk("R7 busy after reset", 128'(busy_o[m]), 128'd0);
            chk("R7 done after reset", 128'(done_o[m]), 128'd0);
            chk("R7 ciphertext after reset", ct_o[m], 128'd0);
        end

        run_op(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 0, 0);
        chk("R1 known answer overlapped", ct_o[0], 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk("R1 known answer gap", ct_o[1], 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk("R2 latency overlapped", 128'(lat_meas[0]), 128'd172);
        chk("R3 latency gap", 128'(lat_meas[1]), 128'd222);

        run_op('0, '0, 0, 0);
        chk("R9 zero vector", ct_o[0], aes_ref('0, '0));
        run_op('1, '1, 0, 0);
        run_op({128{1'b1}}, {128{1'b1}}, 0, 0);
        chk("R9 ones vector", ct_o[1], aes_ref({128{1'b1}}, {128{1'b1}}));

        kk = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        pp = 128'h3243f6a8885a308d313198a2e0370734;
        run_op(kk, pp, 1, 0);
        chk("R8 inputs changed after start overlapped", ct_o[0], aes_ref(kk, pp));
        chk("R8 inputs changed after start gap", ct_o[1], aes_ref(kk, pp));

        run_op(pp, kk, 0, 1);
        chk("R4 start while busy ignored overlapped", ct_o[0], aes_ref(pp, kk));
        chk("R4 start while busy ignored gap", ct_o[1], aes_ref(pp, kk));
        chk("R4 latency unchanged", 128'(lat_meas[1]), 128'd222);

        for (int i = 0; i < 3; i++) begin
            kk = {kk[126:0], kk[127] ^ kk[100]} ^ 128'(i * 977);
            pp = {pp[0], pp[127:1]} ^ kk;
            run_op(kk, pp, 0, 0);
            chk("R9 mixed vector", ct_o[0], aes_ref(kk, pp));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule